// File: doc/BRIEF.md
# Prescaled Reloading Countdown Timer

This block is a single memory-mapped countdown timer channel. A control word chooses one of four tick sources and a power-of-two divider for that source. It also holds the run bit and selects between periodic and single-shot operation. Software places a start value in an interval register. Writing the reload bit copies that value into the live counter. The counter then steps down once per divided tick.

When the count runs out, a sticky expiry flag is set. In periodic operation the counter refills from the interval register and keeps going. In single-shot operation it stops and clears its own run bit. The flag is cleared by writing a one to it. The interrupt line is the flag gated by a separate global interrupt-enable register.

The register port is a plain single-cycle bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational on `bus_addr`. Neither direction has back-pressure, because the register file always accepts and always answers in the same cycle. The tick inputs are single-cycle pulses that are already synchronous to `clk`.

Top module: `prtim_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The register offsets are: interrupt enable at 0x00 (bit 0), expiry status at 0x04 (bit 0), control at 0x10, interval at 0x14 and live count at 0x18. Any other offset reads zero. The control fields are: bit 0 run, bit 1 reload (always reads 0), bits 3:2 source, bits 6:4 divider code, bit 7 single-shot. Control bits above 7 read zero.
- R3: A control write with bit 1 set copies the interval into the counter and restarts the divider phase. An interval of zero is loaded as one.
- R4: With divider code k, the counter drops by one on every 2^k-th tick of the chosen source. A loaded value N therefore expires after N·2^k source ticks.
- R5: The source code selects the tick: 0 = `slow_tick`, 1 = `fast_tick`, 2 = every `clk` cycle, 3 = no tick. Ticks on an unselected input have no effect.
- R6: When a divided tick arrives while the count is 1 or 0, status bit 0 is set.
- R7: In periodic operation (bit 7 clear), expiry refills the counter from the interval, so expiries repeat every interval·2^k source ticks.
- R8: In single-shot operation, expiry leaves the count at 0 and clears run bit 0. No further expiry follows.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If an expiry happens in the same cycle as a clear, the flag stays set.
- R10: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R11: While the run bit is 0, the live count holds its value.
- R12: A write to offset 0x18 sets the live count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| slow_tick | input | 1 | Slow source tick pulse |
| fast_tick | input | 1 | Fast oscillator tick pulse |
| irq | output | 1 | Interrupt request |

## Verification
Random trials vary the interval, the divider code and periodic versus single-shot mode, all on the per-cycle source. Each trial samples status one cycle before and exactly at the predicted expiry. This separates an off-by-one in the divider phase from an off-by-one in the count. A second expiry in periodic trials, and a stopped run bit with a zero count in single-shot trials, separate the two refill paths.

Directed cases cover further distinctions:
- Pulse trains on the two external tick inputs, interleaved with pulses on the unselected input, show which input is actually counted.
- A zero interval makes the counter expire every cycle. That case exposes the clear-versus-expire priority.
- The stopped source and a cleared run bit show that the count is held.

// File: rtl/prtim_pkg.sv
package prtim_pkg;
  localparam int BUS_W = 32;
  localparam int PRE_W = 3;

  localparam logic [7:0] OFS_IE   = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_IVAL = 8'h14;
  localparam logic [7:0] OFS_CNT  = 8'h18;

  // control word bit positions
  localparam int CB_RUN    = 0;
  localparam int CB_RELOAD = 1;
  localparam int CB_SRC    = 2;
  localparam int CB_DIV    = 4;
  localparam int CB_SHOT   = 7;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_FAST = 2'd1,
    SRC_SYS  = 2'd2,
    SRC_OFF  = 2'd3
  } src_e;

  typedef struct packed {
    logic             shot;
    logic [PRE_W-1:0] div;
    src_e             src;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/prtim_tick_gen.sv
module prtim_tick_gen
  import prtim_pkg::*;
#(
  parameter int DIV_W = PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  src_e             src,
  input  logic [DIV_W-1:0] div,
  input  logic             phase_clr,
  output logic             pre_tick
);
  localparam int PH_W = (1 << DIV_W) - 1;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mask;
  logic            src_tick;

  // thermometer mask: low div bits set
  for (genvar i = 0; i < PH_W; i++) begin : g_mask
    assign mask[i] = (i < int'(div));
  end

  always_comb begin
    case (src)
      SRC_SLOW: src_tick = slow_tick;
      SRC_FAST: src_tick = fast_tick;
      SRC_SYS:  src_tick = 1'b1;
      default:  src_tick = 1'b0;
    endcase
  end

  assign pre_tick = src_tick && ((phase_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= '0;
    else if (phase_clr) phase_q <= '0;
    else if (src_tick)  phase_q <= phase_q + 1'b1;
  end

  // R5: a stopped source never yields a divided tick
  p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_OFF) |-> !pre_tick);
endmodule

// File: rtl/prtim_counter.sv
module prtim_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_tick,
  input  logic             shot,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] refill,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             step;

  assign step   = run && pre_tick && !load;
  assign expire = step && (count_q <= ONE);
  assign count  = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (load)   count_q <= load_val;
    else if (expire) count_q <= shot ? '0 : refill;
    else if (step)   count_q <= count_q - ONE;
  end

  // R4: one step down per divided tick
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q > ONE) |=> (count_q == $past(count_q) - ONE));

  // R11: no run, no load -> count holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count_q));
endmodule

// File: rtl/prtim_top.sv
module prtim_top
  import prtim_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              slow_tick,
  input  logic              fast_tick,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic             ie_q;
  logic             stat_q;
  logic [CNT_W-1:0] ival_q;
  logic [CNT_W-1:0] ival_eff;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] load_val;
  logic             wr_ie, wr_stat, wr_ctrl, wr_ival, wr_cnt;
  logic             reload, load, pre_tick, expire;

  assign wr_ie   = bus_wr && (bus_addr == ADDR_W'(OFS_IE));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_ival = bus_wr && (bus_addr == ADDR_W'(OFS_IVAL));
  assign wr_cnt  = bus_wr && (bus_addr == ADDR_W'(OFS_CNT));

  assign reload   = wr_ctrl && bus_wdata[CB_RELOAD];
  assign load     = reload || wr_cnt;
  assign ival_eff = (ival_q == '0) ? CNT_W'(1) : ival_q;
  assign load_val = reload ? ival_eff : bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ie_q   <= 1'b0;
      stat_q <= 1'b0;
      ival_q <= '0;
    end else begin
      if (wr_ie)   ie_q   <= bus_wdata[0];
      if (wr_ival) ival_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl) begin
        ctrl_q.run  <= bus_wdata[CB_RUN];
        ctrl_q.src  <= src_e'(bus_wdata[CB_SRC +: 2]);
        ctrl_q.div  <= bus_wdata[CB_DIV +: PRE_W];
        ctrl_q.shot <= bus_wdata[CB_SHOT];
      end else if (expire && ctrl_q.shot) begin
        ctrl_q.run  <= 1'b0;
      end
      if (expire)                       stat_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) stat_q <= 1'b0;
    end
  end

  prtim_tick_gen #(.DIV_W(PRE_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick),
    .src       (ctrl_q.src),
    .div       (ctrl_q.div),
    .phase_clr (reload),
    .pre_tick  (pre_tick)
  );

  prtim_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .pre_tick (pre_tick),
    .shot     (ctrl_q.shot),
    .load     (load),
    .load_val (load_val),
    .refill   (ival_eff),
    .count    (count),
    .expire   (expire)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_IE):   bus_rdata[0] = ie_q;
      ADDR_W'(OFS_STAT): bus_rdata[0] = stat_q;
      ADDR_W'(OFS_CTRL): bus_rdata = BUS_W'({ctrl_q.shot, ctrl_q.div, ctrl_q.src,
                                             1'b0, ctrl_q.run});
      ADDR_W'(OFS_IVAL): bus_rdata = BUS_W'(ival_q);
      ADDR_W'(OFS_CNT):  bus_rdata = BUS_W'(count);
      default:           bus_rdata = '0;
    endcase
  end

  assign irq = stat_q & ie_q;

  // R6: expiry is recorded
  p_expire_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q);

  // R8: single-shot expiry stops the channel
  p_shot_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.shot && !wr_ctrl) |=> !ctrl_q.run);

  // R9: flag is sticky until a clearing write
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !(wr_stat && bus_wdata[0])) |=> stat_q);

  // R10: interrupt never raised with global enable off
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q);
endmodule

// File: tb/prtim_top_test.sv
module prtim_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        slow_tick = 1'b0;
  logic        fast_tick = 1'b0;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prtim_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slow_tick(slow_tick), .fast_tick(fast_tick), .irq(irq)
  );

  function automatic logic [31:0] ctrl_word(bit run, bit rel, int src, int dv, bit shot);
    return {24'h0, shot, 3'(dv), 2'(src), rel, run};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit fast);
    if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
    @(negedge clk);
    fast_tick = 1'b0; slow_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int n, k, p;
    bit shot, ie;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 ie", v, 0);
    rd(8'h04, v); chk("R1 stat", v, 0);
    rd(8'h10, v); chk("R1 ctrl", v, 0);
    rd(8'h14, v); chk("R1 ival", v, 0);
    rd(8'h18, v); chk("R1 count", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 readback and field layout, R3 reload copy
    wr(8'h14, 32'hDEADBEEF);
    rd(8'h14, v); chk("R2 ival", v, 32'hDEADBEEF);
    wr(8'h10, 32'h0000_03FE);
    rd(8'h10, v); chk("R2 ctrl fields", v, 32'h0000_00FC);
    rd(8'h08, v); chk("R2 unmapped", v, 0);
    rd(8'h18, v); chk("R3 reload copies", v, 32'hDEADBEEF);

    // R5 stopped source / R11 run bit cleared
    wr(8'h10, ctrl_word(1, 0, 3, 0, 0));
    idle(20);
    rd(8'h18, v); chk("R5 src off holds", v, 32'hDEADBEEF);
    wr(8'h10, ctrl_word(0, 0, 2, 0, 0));
    idle(20);
    rd(8'h18, v); chk("R11 not running holds", v, 32'hDEADBEEF);

    // R12 direct count write
    wr(8'h18, 32'h0000_1234);
    rd(8'h18, v); chk("R12 count write", v, 32'h1234);

    // random trials: R4 R6 R7 R8 R9 R10
    for (int t = 0; t < 24; t++) begin
      n = 2 + int'($urandom_range(0, 31));
      k = int'($urandom_range(0, 3));
      shot = 1'($urandom_range(0, 1));
      ie = 1'($urandom_range(0, 1));
      p = n << k;
      wr(8'h00, 32'(ie));
      wr(8'h14, 32'(n));
      wr(8'h10, ctrl_word(1, 1, 2, k, shot));
      idle(p - 1);
      rd(8'h04, v); chk("R4 before expiry", v, 0);
      idle(1);
      rd(8'h04, v); chk("R6 at expiry", v, 1);
      chk("R10 irq gate", 32'(irq), 32'(ie));
      if (shot) begin
        rd(8'h10, v); chk("R8 run cleared", 32'(v[0]), 0);
        rd(8'h18, v); chk("R8 count zero", v, 0);
        wr(8'h04, 32'h1);
        idle(p + 2);
        rd(8'h04, v); chk("R8 no second expiry", v, 0);
      end else begin
        wr(8'h04, 32'h1);
        idle(p - 2);
        rd(8'h04, v); chk("R9 cleared / R7 pending", v, 0);
        idle(1);
        rd(8'h04, v); chk("R7 periodic repeat", v, 1);
        wr(8'h10, 0);
        wr(8'h04, 32'h1);
      end
    end

    // R3 zero interval acts as one; R9 priority and write-zero
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h10, ctrl_word(1, 1, 2, 0, 0));
    idle(1);
    rd(8'h04, v); chk("R3 zero interval", v, 1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R9 expiry beats clear", v, 1);
    wr(8'h10, 0);
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R9 write zero ignored", v, 1);
    chk("R10 irq off when ie=0", 32'(irq), 0);
    wr(8'h00, 32'h1);
    chk("R10 irq on", 32'(irq), 1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R9 clear", v, 0);
    chk("R10 irq drops", 32'(irq), 0);

    // R5 fast source with divide by 2, slow ticks ignored
    wr(8'h14, 32'd3);
    wr(8'h10, ctrl_word(1, 1, 1, 1, 1));
    for (int i = 0; i < 5; i++) begin pulse(1); pulse(0); end
    rd(8'h04, v); chk("R5 fast 5 ticks", v, 0);
    pulse(1);
    rd(8'h04, v); chk("R5 fast 6 ticks", v, 1);
    wr(8'h04, 32'h1);

    // R5 slow source, fast ticks ignored
    wr(8'h14, 32'd2);
    wr(8'h10, ctrl_word(1, 1, 0, 0, 1));
    pulse(0); pulse(1); pulse(1);
    rd(8'h04, v); chk("R5 slow 1 tick", v, 0);
    pulse(0);
    rd(8'h04, v); chk("R5 slow 2 ticks", v, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule